// File: doc/BRIEF.md
# Clock Level Frequency Matcher

This block chooses, from a table of available source clock rates, the one that best serves a requested output rate when the source is brought down by an integer divider. For every table entry it derives the smallest integer divider that keeps the divided rate at or below the request, rounding the quotient entry/request upward. It then measures how far the divided rate falls short of the request. The entry with the smallest shortfall wins.

The table has up to `MAX_LEVELS` entries and is loaded through a simple write port. A search is launched with a one-cycle `start` pulse. It captures the table length, the requested rate and an exact-only flag, and then walks the entries in index order. Both divisions for an entry share one iterative shift-subtract divider, which produces one quotient bit per cycle. If an entry divides down to the request exactly, the search stops at that entry. When the search ends, a one-cycle `done` pulse reports the chosen index, the chosen rate and a success flag. These outputs hold until the next `done`.

Top module: `clk_rate_matcher`

## Requirements
- R1: While reset is held, and until the first search ends, `done`, `busy`, `ok`, `sel_idx` and `sel_rate` are all zero.
- R2: For entry rate E and request Q, the divider is D = ceil(E/Q) and the shortfall is Q - floor(E/D). On success `sel_rate` is the entry with the smallest shortfall and `sel_idx` is its table position, where position 0 is the first entry written.
- R3: An entry replaces the current best only if its shortfall is strictly smaller. Among equal shortfalls the lowest index is reported.
- R4: A shortfall of zero ends the search at that entry with `ok`=1. With an exact hit at index 0, `done` arrives no more than 2*RATE_W+8 cycles after the `start` cycle, whatever the table length.
- R5: If no entry gives a zero shortfall and `exact_only` was 1 at `start`, the result is `ok`=0 with `sel_idx`=0 and `sel_rate`=0.
- R6: If no entry gives a zero shortfall and `exact_only` was 0 at `start`, the result is `ok`=1 with the best entry.
- R7: A `start` with a table length of 0 or a request of 0 is rejected. `done` is high in the cycle after the `start` cycle, with `ok`=0, `sel_idx`=0 and `sel_rate`=0.
- R8: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted `start` until `done`, and low while `done` is high. The results hold unchanged until the next `done`.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running search completes with its original operands, and no further `done` follows.
- R10: A `tbl_len` above `MAX_LEVELS` is treated as `MAX_LEVELS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tbl_wr_en | input | 1 | Write strobe for the rate table |
| tbl_wr_idx | input | IDX_W | Table position to write |
| tbl_wr_rate | input | RATE_W | Rate value to store |
| tbl_len | input | CNT_W | Number of valid table entries, captured at start |
| start | input | 1 | One-cycle pulse that launches a search |
| req_rate | input | RATE_W | Requested rate, captured at start |
| exact_only | input | 1 | When set, only a zero shortfall counts as success |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| ok | output | 1 | Success flag of the last search |
| sel_idx | output | IDX_W | Chosen table index |
| sel_rate | output | RATE_W | Chosen table rate |

## Verification
A rejected `start` must raise `done` in the first cycle after the `start` cycle. An exact hit on entry 0 must finish within 2*RATE_W+8 cycles. Any other search finishes after a data-dependent number of divider passes, so the bench counts cycles from `start` and compares the results only in the cycle where `done` is high, against a bench-side model of the search. Every sample is taken on the falling edge. That cycle count is also used to check the rejection latency and the early exit, and the check that results hold looks at the cycles after `done`.

// File: rtl/rate_match_pkg.sv
package rate_match_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CEIL,
    ST_FLOOR,
    ST_EVAL
  } srch_state_t;

endpackage

// File: rtl/rate_table.sv
module rate_table #(
  parameter int MAX_LEVELS = 32,
  parameter int RATE_W     = 32,
  parameter int IDX_W      = $clog2(MAX_LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [RATE_W-1:0] wr_rate,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [RATE_W-1:0] rd_rate
);

  logic [RATE_W-1:0] ent_q [MAX_LEVELS];

  for (genvar g = 0; g < MAX_LEVELS; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q[g] <= '0;
      else if (hit) ent_q[g] <= wr_rate;
    end
  end

  assign rd_rate = ent_q[rd_idx];

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int W  = 33,
  parameter int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         fin,
  output logic [W-1:0] quo
);

  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, den_q, den_d, num_q, num_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, fin_q, fin_d;
  logic [W:0]    shifted, diff;
  logic          take;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign take    = shifted >= {1'b0, den_q};

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    den_d = den_q;
    num_d = num_q;
    cnt_d = cnt_q;
    run_d = run_q;
    fin_d = 1'b0;
    if (go) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      num_d = num;
      cnt_d = CW'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = take ? diff[W-1:0] : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], take};
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      num_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      den_q <= den_d;
      num_q <= num_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      fin_q <= fin_d;
    end
  end

  assign fin = fin_q;
  assign quo = quo_q;

  AST_DIV_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && den_q != '0) |->
      (({{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q}) <= {{W{1'b0}}, num_q}) &&
      ((({{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q}) + {{W{1'b0}}, den_q}) > {{W{1'b0}}, num_q})); // R2

endmodule

// File: rtl/rate_search_ctrl.sv
module rate_search_ctrl
  import rate_match_pkg::*;
#(
  parameter int RATE_W     = 32,
  parameter int MAX_LEVELS = 32,
  parameter int IDX_W      = $clog2(MAX_LEVELS),
  parameter int CNT_W      = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] req_rate,
  input  logic              exact_only,
  input  logic [CNT_W-1:0]  tbl_len,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [RATE_W-1:0] rd_rate,
  output logic              div_go,
  output logic [RATE_W:0]   div_num,
  output logic [RATE_W:0]   div_den,
  input  logic              div_fin,
  input  logic [RATE_W:0]   div_quo,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [RATE_W-1:0] sel_rate
);

  localparam int DW = RATE_W + 1;

  srch_state_t       st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, bidx_q, bidx_d, sidx_q, sidx_d;
  logic [CNT_W-1:0]  len_q, len_d, len_eff;
  logic [RATE_W-1:0] req_q, req_d, delta_q, delta_d;
  logic [RATE_W-1:0] brate_q, brate_d, srate_q, srate_d;
  logic [DW-1:0]     best_q, best_d;
  logic              exact_q, exact_d, done_q, done_d, ok_q, ok_d;
  logic              is_last, better;

  assign len_eff = (tbl_len > CNT_W'(MAX_LEVELS)) ? CNT_W'(MAX_LEVELS) : tbl_len;
  assign is_last = (CNT_W'(idx_q) + CNT_W'(1)) == len_q;
  assign better  = {1'b0, delta_q} < best_q;
  assign rd_idx  = idx_q;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    len_d   = len_q;
    req_d   = req_q;
    exact_d = exact_q;
    delta_d = delta_q;
    best_d  = best_q;
    bidx_d  = bidx_q;
    brate_d = brate_q;
    ok_d    = ok_q;
    sidx_d  = sidx_q;
    srate_d = srate_q;
    done_d  = 1'b0;
    div_go  = 1'b0;
    div_num = '0;
    div_den = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (len_eff == '0 || req_rate == '0) begin
            done_d  = 1'b1;
            ok_d    = 1'b0;
            sidx_d  = '0;
            srate_d = '0;
          end else begin
            st_d    = ST_LOAD;
            idx_d   = '0;
            len_d   = len_eff;
            req_d   = req_rate;
            exact_d = exact_only;
            best_d  = '1;
            bidx_d  = '0;
            brate_d = '0;
          end
        end
      end
      ST_LOAD: begin
        div_go  = 1'b1;
        div_num = {1'b0, rd_rate} + {1'b0, req_q} - DW'(1);
        div_den = {1'b0, req_q};
        st_d    = ST_CEIL;
      end
      ST_CEIL: begin
        if (div_fin) begin
          if (div_quo == '0) begin
            delta_d = req_q;
            st_d    = ST_EVAL;
          end else begin
            div_go  = 1'b1;
            div_num = {1'b0, rd_rate};
            div_den = div_quo;
            st_d    = ST_FLOOR;
          end
        end
      end
      ST_FLOOR: begin
        if (div_fin) begin
          delta_d = req_q - RATE_W'(div_quo);
          st_d    = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (better) begin
          best_d  = {1'b0, delta_q};
          bidx_d  = idx_q;
          brate_d = rd_rate;
        end
        if (delta_q == '0) begin
          done_d  = 1'b1;
          ok_d    = 1'b1;
          sidx_d  = idx_q;
          srate_d = rd_rate;
          st_d    = ST_IDLE;
        end else if (is_last) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
          if (exact_q) begin
            ok_d    = 1'b0;
            sidx_d  = '0;
            srate_d = '0;
          end else begin
            ok_d    = 1'b1;
            sidx_d  = better ? idx_q : bidx_q;
            srate_d = better ? rd_rate : brate_q;
          end
        end else begin
          idx_d = idx_q + IDX_W'(1);
          st_d  = ST_LOAD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      req_q   <= '0;
      exact_q <= 1'b0;
      delta_q <= '0;
      best_q  <= '0;
      bidx_q  <= '0;
      brate_q <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      sidx_q  <= '0;
      srate_q <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      req_q   <= req_d;
      exact_q <= exact_d;
      delta_q <= delta_d;
      best_q  <= best_d;
      bidx_q  <= bidx_d;
      brate_q <= brate_d;
      done_q  <= done_d;
      ok_q    <= ok_d;
      sidx_q  <= sidx_d;
      srate_q <= srate_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign ok       = ok_q;
  assign sel_idx  = sidx_q;
  assign sel_rate = srate_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R8
  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && (len_eff == '0 || req_rate == '0)) |=> (done_q && !ok_q)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start) |=> $stable(req_q)); // R9
  AST_EXACT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ok_q && exact_q) |-> (delta_q == '0)); // R5
  AST_DELTA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVAL) |-> (delta_q <= req_q)); // R2
  AST_BEST_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVAL && !is_last && delta_q != '0) |=> (best_q <= $past(best_q))); // R3

endmodule

// File: rtl/clk_rate_matcher.sv
module clk_rate_matcher #(
  parameter int RATE_W     = 32,
  parameter int MAX_LEVELS = 32,
  parameter int IDX_W      = $clog2(MAX_LEVELS),
  parameter int CNT_W      = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic [RATE_W-1:0] tbl_wr_rate,
  input  logic [CNT_W-1:0]  tbl_len,
  input  logic              start,
  input  logic [RATE_W-1:0] req_rate,
  input  logic              exact_only,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [RATE_W-1:0] sel_rate
);

  localparam int DW = RATE_W + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [IDX_W-1:0]  rd_idx;
  logic [RATE_W-1:0] rd_rate;
  logic              div_go, div_fin;
  logic [DW-1:0]     div_num, div_den, div_quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rate_table #(.MAX_LEVELS(MAX_LEVELS), .RATE_W(RATE_W), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (tbl_wr_en),
    .wr_idx  (tbl_wr_idx),
    .wr_rate (tbl_wr_rate),
    .rd_idx  (rd_idx),
    .rd_rate (rd_rate)
  );

  rate_divider #(.W(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .fin   (div_fin),
    .quo   (div_quo)
  );

  rate_search_ctrl #(
    .RATE_W(RATE_W), .MAX_LEVELS(MAX_LEVELS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .req_rate   (req_rate),
    .exact_only (exact_only),
    .tbl_len    (tbl_len),
    .rd_idx     (rd_idx),
    .rd_rate    (rd_rate),
    .div_go     (div_go),
    .div_num    (div_num),
    .div_den    (div_den),
    .div_fin    (div_fin),
    .div_quo    (div_quo),
    .busy       (busy),
    .done       (done),
    .ok         (ok),
    .sel_idx    (sel_idx),
    .sel_rate   (sel_rate)
  );

endmodule

// File: tb/clk_rate_matcher_tb_top.sv
`timescale 1ns/1ps
module clk_rate_matcher_tb_top;

  localparam int RATE_W = 32;
  localparam int LEVELS = 32;
  localparam int IW     = 5;
  localparam int CW     = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tbl_wr_en;
  logic [IW-1:0]     tbl_wr_idx;
  logic [RATE_W-1:0] tbl_wr_rate;
  logic [CW-1:0]     tbl_len;
  logic              start;
  logic [RATE_W-1:0] req_rate;
  logic              exact_only;
  logic              busy, done, ok;
  logic [IW-1:0]     sel_idx;
  logic [RATE_W-1:0] sel_rate;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit busy_gap;
  longint unsigned tbl_m [LEVELS];

  always #2.5 clk = ~clk;

  clk_rate_matcher #(.RATE_W(RATE_W), .MAX_LEVELS(LEVELS)) dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_rate(tbl_wr_rate), .tbl_len(tbl_len), .start(start), .req_rate(req_rate),
    .exact_only(exact_only), .busy(busy), .done(done), .ok(ok),
    .sel_idx(sel_idx), .sel_rate(sel_rate)
  );

  task automatic chk(input string tag, input bit cond, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_match(input int unsigned len, input longint unsigned req, input bit ex,
                                    output bit eok, output int eidx, output longint unsigned erate);
    int unsigned n;
    longint unsigned best, d, q, delta, br;
    int bi;
    n = (len > LEVELS) ? LEVELS : len;
    eok = 0; eidx = 0; erate = 0;
    if (n == 0 || req == 0) return;
    best = 64'h1_FFFF_FFFF; bi = 0; br = 0;
    for (int i = 0; i < int'(n); i++) begin
      d = (tbl_m[i] + req - 1) / req;
      q = (d == 0) ? 0 : tbl_m[i] / d;
      delta = req - q;
      if (delta < best) begin
        best = delta; bi = i; br = tbl_m[i];
        if (delta == 0) begin
          eok = 1; eidx = bi; erate = br;
          return;
        end
      end
    end
    if (!ex) begin
      eok = 1; eidx = bi; erate = br;
    end
  endfunction

  task automatic wr_entry(input int i);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = IW'(i); tbl_wr_rate = tbl_m[i][31:0];
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic run(input longint unsigned req, input bit ex, input int unsigned len, output int cyc);
    @(negedge clk);
    req_rate = req[31:0]; exact_only = ex; tbl_len = CW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1; busy_gap = 0;
    while (!done && cyc < 5000) begin
      if (!busy) busy_gap = 1;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_res(input string tag, input longint unsigned req, input bit ex, input int unsigned len);
    bit eok; int eidx; longint unsigned erate;
    ref_match(len, req, ex, eok, eidx, erate);
    checks++;
    if (done !== 1'b1 || ok !== eok || sel_idx !== IW'(eidx) || sel_rate !== erate[31:0]) begin
      errors++;
      $display("FAIL %s actual done=%0b ok=%0b idx=%0d rate=%0d expected ok=%0b idx=%0d rate=%0d",
               tag, done, ok, sel_idx, sel_rate, eok, eidx, erate);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    bit eok; int eidx; longint unsigned erate;
    longint unsigned req;
    void'($urandom(32'h00C1_0C4A));
    rst_n = 1'b0; tbl_wr_en = 0; tbl_wr_idx = 0; tbl_wr_rate = 0;
    tbl_len = 0; start = 0; req_rate = 0; exact_only = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {done, busy, ok} == 3'b000 && sel_idx == 0 && sel_rate == 0,
        longint'({done, busy, ok}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: empty table
    run(1000, 0, 0, cyc);
    chk("R7 empty table latency", cyc == 1, cyc, 1);
    chk("R7 empty table ok", ok == 0 && sel_rate == 0, ok, 0);
    @(negedge clk);
    chk("R8 done single pulse", done == 0, done, 0);

    tbl_m[0] = 100_000_000; tbl_m[1] = 200_000_000; tbl_m[2] = 50_000_000;
    for (int i = 0; i < 3; i++) wr_entry(i);

    // R7: zero request
    run(0, 0, 3, cyc);
    chk("R7 zero request latency", cyc == 1, cyc, 1);
    chk("R7 zero request ok", ok == 0, ok, 0);

    // R6: best non-exact
    run(30_000_000, 0, 3, cyc);
    check_res("R6 best non-exact", 30_000_000, 0, 3);
    chk("R8 busy through search", busy_gap == 0, busy_gap, 0);
    repeat (5) @(negedge clk);
    chk("R8 results hold", ok == 1 && sel_idx == 1 && sel_rate == 200_000_000 && !busy,
        sel_rate, 200_000_000);

    // R5: exact required, none present
    run(30_000_000, 1, 3, cyc);
    check_res("R5 exact-only failure", 30_000_000, 1, 3);

    // R3: tie keeps lower index
    tbl_m[0] = 90_000_000; tbl_m[1] = 70_000_001; tbl_m[2] = 70_000_001;
    for (int i = 0; i < 3; i++) wr_entry(i);
    run(40_000_000, 0, 3, cyc);
    check_res("R3 tie lowest index", 40_000_000, 0, 3);
    chk("R3 tie index", sel_idx == 1, sel_idx, 1);

    // R4: exact hit at index 0 in a full table
    for (int i = 0; i < LEVELS; i++) begin
      tbl_m[i] = (i == 0) ? 48_000_000 : 64'($urandom_range(1_000_000, 400_000_000));
      wr_entry(i);
    end
    run(12_000_000, 1, LEVELS, cyc);
    check_res("R4 exact hit", 12_000_000, 1, LEVELS);
    chk("R4 early exit latency", cyc <= 2 * RATE_W + 8, cyc, 2 * RATE_W + 8);

    // R10: length above table size clamps
    tbl_m[31] = 77_000_000; wr_entry(31);
    run(11_000_000, 1, 63, cyc);
    check_res("R10 length clamp", 11_000_000, 1, 63);

    // R9: start while busy is ignored
    req = 23_456_789;
    @(negedge clk);
    req_rate = req[31:0]; exact_only = 0; tbl_len = CW'(LEVELS); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    req_rate = 32'd5_000_000; exact_only = 1; tbl_len = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    check_res("R9 busy start ignored", req, 0, LEVELS);
    cyc = 0;
    repeat (100) begin @(negedge clk); if (done) cyc++; end
    chk("R9 no extra done", cyc == 0, cyc, 0);

    // R2: random searches
    for (int t = 0; t < 30; t++) begin
      int unsigned n;
      bit ex;
      n = $urandom_range(1, LEVELS);
      req = 64'($urandom_range(100_000, 100_000_000));
      for (int i = 0; i < int'(n); i++) tbl_m[i] = 64'($urandom_range(1_000_000, 400_000_000));
      if ($urandom_range(0, 2) == 0) begin
        int j;
        j = $urandom_range(0, n - 1);
        tbl_m[j] = req * 64'($urandom_range(1, 8));
      end
      for (int i = 0; i < int'(n); i++) wr_entry(i);
      ex = 1'($urandom_range(0, 1));
      run(req, ex, n, cyc);
      check_res("R2 random search", req, ex, n);
    end

    ref_match(0, 0, 0, eok, eidx, erate);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule